// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block steps a processor subsystem through three power states: idle, stop and deep-stop. It watches a standby-for-interrupt level from the core and a stop-request bit written by software. To enter stop, it runs two handshakes with the bus controller. The block drives the clock enables for the CPU and for the system, the oscillator and PLL enables, the power-gate control for the core domain and a reset that reaches only the core.

A rising edge on the standby level stops only the CPU clock, and an accepted wake source starts it again. A rising edge on the stop bit drains the core's bus traffic, gates the CPU clock, drains all remaining bus traffic, and then stops every clock. If software allowed it, the oscillator is stopped too. If deep-stop was selected, the core domain is also switched off. On wake, the block waits for a programmable oscillator settle time and then a programmable PLL lock time before any clock runs again. After a deep-stop, it powers the core domain back up and holds the core in reset for a fixed interval once power is good.

Top module: `lpm_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, mode_o is 0 (normal) and every enable output and core_pwr_on_o is 1. Both drain requests and core_rst_o are 0. A stop bit that is already high when reset is released does not start a stop entry.
- R2: A rising edge of core_standby_i in normal mode sets cpu_clk_en_o to 0 and mode_o to 1 (idle) in the next cycle. sys_clk_en_o, osc_en_o and pll_en_o stay 1.
- R3: wake_src_i bits mean: bit 0 interrupt, bit 1 RTC alarm, bit 2 RTC tick, bit 3 battery fault, bit 4 external reset request. A source counts only where wake_en_i has a 1. Idle is left on an enabled source in bits 0 to 3, and cpu_clk_en_o returns to 1 with mode_o 0. Bit 4, or any disabled source, leaves the block in idle.
- R4: Only a low-to-high transition of stop_req_i starts a stop entry. A stop bit that stays high after wake-up starts no new entry until it has been low for a cycle.
- R5: Stop entry order: first, core_down_req_o rises with the CPU clock still running. After core_down_ack_i, core_down_req_o falls, cpu_clk_en_o falls and bus_drain_req_o rises. After bus_drain_ack_i, the stopped state is reached.
- R6: In the stopped state, sys_clk_en_o, cpu_clk_en_o and pll_en_o are 0. osc_en_o is 0 only if osc_off_cfg_i was 1 at the stop trigger. mode_o is 2.
- R7: If deep_cfg_i was 1 at the stop trigger, core_pwr_on_o is 0 in the stopped state and mode_o is 3. The power gate opens only in the cycle after the final bus acknowledge.
- R8: Stop and deep-stop are left on an enabled source in bits 0, 1, 2 or 4 of wake_src_i. The battery fault (bit 3) and disabled sources are ignored there.
- R9: Take the clock edge that samples the wake as cycle 0. sys_clk_en_o rises after the edge osc_cnt_i + pll_cnt_i + 2. If the oscillator was left running, the oscillator wait is skipped and the rise comes after the edge pll_cnt_i + 1. No clock enable is 1 before then.
- R10: On wake from deep-stop, core_pwr_on_o and core_rst_o become 1 together with sys_clk_en_o, and cpu_clk_en_o stays 0. Once core_pwr_good_i is 1, core_rst_o stays high for exactly 8 more cycles. Only after that do cpu_clk_en_o return to 1 and mode_o return to 0.
- R11: mode_o is 4 (waking) from the cycle after the wake until the clocks are released.
- R12: Each accepted wake makes wake_pulse_o high for exactly one cycle, together with the state change. In that cycle wake_class_o holds the enabled sources that were accepted for the current state, in the bit order of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_standby_i | input | 1 | Core standby-for-interrupt level |
| stop_req_i | input | 1 | Software stop-request bit |
| deep_cfg_i | input | 1 | Select deep-stop (power-gate the core) |
| osc_off_cfg_i | input | 1 | Allow the oscillator to stop in stop mode |
| wake_src_i | input | 5 | Wake sources: interrupt, RTC alarm, RTC tick, battery fault, external reset |
| wake_en_i | input | 5 | Per-source wake enable |
| osc_cnt_i | input | 16 | Oscillator settle cycles |
| pll_cnt_i | input | 16 | PLL lock cycles |
| core_down_ack_i | input | 1 | Bus controller: core traffic drained |
| bus_drain_ack_i | input | 1 | Bus controller: all traffic drained |
| core_pwr_good_i | input | 1 | Core power domain is up |
| core_down_req_o | output | 1 | Request to drain core bus traffic |
| bus_drain_req_o | output | 1 | Request to drain all bus traffic |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| core_pwr_on_o | output | 1 | Core power-gate control, 1 = powered |
| core_rst_o | output | 1 | Reset to the core only |
| mode_o | output | 3 | 0 normal, 1 idle, 2 stop, 3 deep-stop, 4 waking |
| wake_pulse_o | output | 1 | One-cycle wake flag |
| wake_class_o | output | 5 | Accepted wake sources at the last wake |

## Verification
The bench measures the wake latency exactly, for zero and non-zero settle and lock counts and with the oscillator both stopped and kept running. A design that started the count one cycle late, or that did not skip the oscillator wait, would release the clocks on the wrong cycle. The bench also checks which sources each state accepts: a battery fault given while stopped, an external reset given while idle, and masked sources. A design that shared one wake set between the two states would wake on those. The bench holds the stop bit high across a wake and expects no new entry, which catches a level-triggered design. It counts the cycles of the core reset after a deep wake, which catches a hold interval that is off by one or that starts before power-good.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int WAKE_N = 5;

    // wake source bit positions
    localparam int WK_IRQ   = 0;
    localparam int WK_ALARM = 1;
    localparam int WK_TICK  = 2;
    localparam int WK_BATT  = 3;
    localparam int WK_XRST  = 4;

    localparam logic [WAKE_N-1:0] IDLE_WAKE_SET =
        (WAKE_N'(1) << WK_IRQ) | (WAKE_N'(1) << WK_ALARM) |
        (WAKE_N'(1) << WK_TICK) | (WAKE_N'(1) << WK_BATT);
    localparam logic [WAKE_N-1:0] STOP_WAKE_SET =
        (WAKE_N'(1) << WK_IRQ) | (WAKE_N'(1) << WK_ALARM) |
        (WAKE_N'(1) << WK_TICK) | (WAKE_N'(1) << WK_XRST);

    typedef enum logic [3:0] {
        S_RUN, S_IDLE, S_CORE_DRAIN, S_BUS_DRAIN, S_HALT,
        S_OSC_WAIT, S_PLL_WAIT, S_PWR_UP, S_CORE_RST
    } lpm_state_e;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_IDLE   = 3'd1,
        MODE_STOP   = 3'd2,
        MODE_DEEP   = 3'd3,
        MODE_WAKING = 3'd4
    } lpm_mode_e;

    typedef struct packed {
        logic cpu;
        logic sys;
        logic osc;
        logic pll;
        logic pwr;
        logic rst;
        logic core_req;
        logic bus_req;
    } lpm_ctrl_t;

    function automatic lpm_ctrl_t decode_ctrl(lpm_state_e st, logic deep, logic osc_keep);
        lpm_ctrl_t c;
        c = '{cpu: 1'b1, sys: 1'b1, osc: 1'b1, pll: 1'b1, pwr: 1'b1,
              rst: 1'b0, core_req: 1'b0, bus_req: 1'b0};
        case (st)
            S_IDLE:       c.cpu = 1'b0;
            S_CORE_DRAIN: c.core_req = 1'b1;
            S_BUS_DRAIN: begin
                c.cpu     = 1'b0;
                c.bus_req = 1'b1;
            end
            S_HALT: begin
                c.cpu = 1'b0; c.sys = 1'b0; c.pll = 1'b0;
                c.osc = osc_keep; c.pwr = ~deep;
            end
            S_OSC_WAIT: begin
                c.cpu = 1'b0; c.sys = 1'b0; c.pll = 1'b0; c.pwr = ~deep;
            end
            S_PLL_WAIT: begin
                c.cpu = 1'b0; c.sys = 1'b0; c.pwr = ~deep;
            end
            S_PWR_UP, S_CORE_RST: begin
                c.cpu = 1'b0; c.rst = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic lpm_mode_e state_mode(lpm_state_e st, logic deep);
        case (st)
            S_RUN:                         return MODE_NORMAL;
            S_IDLE:                        return MODE_IDLE;
            S_CORE_DRAIN, S_BUS_DRAIN,
            S_HALT:                        return deep ? MODE_DEEP : MODE_STOP;
            default:                       return MODE_WAKING;
        endcase
    endfunction

endpackage

// File: rtl/lpm_edge_rise.sv
module lpm_edge_rise #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RESET_LEVEL;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    // a held level yields a single trigger
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load_i)         cnt_q <= value_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    assert_timer_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (!load_i && done_o) |=> done_o);
endmodule

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WAKE_N-1:0] src_i,
    input  logic [WAKE_N-1:0] en_i,
    input  logic [WAKE_N-1:0] set_i,
    input  logic              armed_i,
    output logic              hit_o,
    output logic              pulse_o,
    output logic [WAKE_N-1:0] class_o
);
    logic [WAKE_N-1:0] accepted;

    assign accepted = src_i & en_i & set_i;
    assign hit_o    = armed_i & (|accepted);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= 1'b0;
            class_o <= '0;
        end else begin
            pulse_o <= hit_o;
            if (hit_o) class_o <= accepted;
        end
    end

    assert_pulse_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
    assert_class_nonempty_R12: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (class_o != '0));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RST_HOLD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_standby_i,
    input  logic              stop_req_i,
    input  logic              deep_cfg_i,
    input  logic              osc_off_cfg_i,
    input  logic [WAKE_N-1:0] wake_src_i,
    input  logic [WAKE_N-1:0] wake_en_i,
    input  logic [CNT_W-1:0]  osc_cnt_i,
    input  logic [CNT_W-1:0]  pll_cnt_i,
    input  logic              core_down_ack_i,
    input  logic              bus_drain_ack_i,
    input  logic              core_pwr_good_i,
    output logic              core_down_req_o,
    output logic              bus_drain_req_o,
    output logic              cpu_clk_en_o,
    output logic              sys_clk_en_o,
    output logic              osc_en_o,
    output logic              pll_en_o,
    output logic              core_pwr_on_o,
    output logic              core_rst_o,
    output logic [2:0]        mode_o,
    output logic              wake_pulse_o,
    output logic [WAKE_N-1:0] wake_class_o
);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_HOLD - 1);

    lpm_state_e        state_q, state_d;
    logic              deep_q, osc_keep_q;
    logic              stop_rise, sby_rise;
    logic              wake_hit, wake_armed;
    logic [WAKE_N-1:0] wake_set;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_value;
    lpm_ctrl_t         ctrl;

    lpm_edge_rise #(.RESET_LEVEL(1'b1)) u_stop_edge (
        .clk(clk), .rst(rst), .level_i(stop_req_i), .rise_o(stop_rise));

    lpm_edge_rise #(.RESET_LEVEL(1'b1)) u_sby_edge (
        .clk(clk), .rst(rst), .level_i(core_standby_i), .rise_o(sby_rise));

    assign wake_armed = (state_q == S_IDLE) || (state_q == S_HALT);
    assign wake_set   = (state_q == S_IDLE) ? IDLE_WAKE_SET : STOP_WAKE_SET;

    lpm_wake_filter u_wake (
        .clk(clk), .rst(rst), .src_i(wake_src_i), .en_i(wake_en_i),
        .set_i(wake_set), .armed_i(wake_armed), .hit_o(wake_hit),
        .pulse_o(wake_pulse_o), .class_o(wake_class_o));

    lpm_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_load), .value_i(tmr_value),
        .done_o(tmr_done));

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_value = '0;
        case (state_q)
            S_RUN: begin
                if (stop_rise)     state_d = S_CORE_DRAIN;
                else if (sby_rise) state_d = S_IDLE;
            end
            S_IDLE:       if (wake_hit) state_d = S_RUN;
            S_CORE_DRAIN: if (core_down_ack_i) state_d = S_BUS_DRAIN;
            S_BUS_DRAIN:  if (bus_drain_ack_i) state_d = S_HALT;
            S_HALT: begin
                if (wake_hit) begin
                    tmr_load = 1'b1;
                    if (osc_keep_q) begin
                        state_d   = S_PLL_WAIT;
                        tmr_value = pll_cnt_i;
                    end else begin
                        state_d   = S_OSC_WAIT;
                        tmr_value = osc_cnt_i;
                    end
                end
            end
            S_OSC_WAIT: begin
                if (tmr_done) begin
                    state_d   = S_PLL_WAIT;
                    tmr_load  = 1'b1;
                    tmr_value = pll_cnt_i;
                end
            end
            S_PLL_WAIT: if (tmr_done) state_d = deep_q ? S_PWR_UP : S_RUN;
            S_PWR_UP: begin
                if (core_pwr_good_i) begin
                    state_d   = S_CORE_RST;
                    tmr_load  = 1'b1;
                    tmr_value = RST_LOAD;
                end
            end
            S_CORE_RST: if (tmr_done) state_d = S_RUN;
            default:    state_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_RUN;
            deep_q     <= 1'b0;
            osc_keep_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == S_RUN && stop_rise) begin
                deep_q     <= deep_cfg_i;
                osc_keep_q <= ~osc_off_cfg_i;
            end
        end
    end

    assign ctrl            = decode_ctrl(state_q, deep_q, osc_keep_q);
    assign cpu_clk_en_o    = ctrl.cpu;
    assign sys_clk_en_o    = ctrl.sys;
    assign osc_en_o        = ctrl.osc;
    assign pll_en_o        = ctrl.pll;
    assign core_pwr_on_o   = ctrl.pwr;
    assign core_rst_o      = ctrl.rst;
    assign core_down_req_o = ctrl.core_req;
    assign bus_drain_req_o = ctrl.bus_req;
    assign mode_o          = state_mode(state_q, deep_q);

    assert_entry_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(core_down_req_o) |-> ($past(stop_req_i) && !$past(stop_req_i, 2)));
    assert_drain_after_core_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_drain_req_o) |-> $past(core_down_ack_i));
    assert_gate_after_bus_ack_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(core_pwr_on_o) |-> $past(bus_drain_ack_i));
    assert_clocks_follow_pll_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_clk_en_o) |-> $past(pll_en_o));
    assert_core_rst_blocks_cpu_R10: assert property (@(posedge clk) disable iff (rst)
        core_rst_o |-> !cpu_clk_en_o);
    assert_rst_release_needs_power_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> core_pwr_good_i);
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;
    localparam logic [4:0] STOP_SET = 5'b10111;

    // wake-latency vectors
    localparam int         V_OSC [NV] = '{3, 0, 7, 2, 10};
    localparam int         V_PLL [NV] = '{5, 0, 2, 4, 1};
    localparam logic       V_OFF [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic       V_DEEP[NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [4:0] V_SRC [NV] = '{5'b00001, 5'b00010, 5'b00100, 5'b10000, 5'b01101};

    logic clk = 1'b0, rst = 1'b1;
    logic core_standby_i = 0, stop_req_i = 0, deep_cfg_i = 0, osc_off_cfg_i = 0;
    logic [4:0] wake_src_i = '0, wake_en_i = 5'b11111;
    logic [15:0] osc_cnt_i = '0, pll_cnt_i = '0;
    logic core_down_ack_i = 0, bus_drain_ack_i = 0, core_pwr_good_i = 1;
    logic core_down_req_o, bus_drain_req_o, cpu_clk_en_o, sys_clk_en_o;
    logic osc_en_o, pll_en_o, core_pwr_on_o, core_rst_o, wake_pulse_o;
    logic [2:0] mode_o;
    logic [4:0] wake_class_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_sequencer u_lpm_sequencer (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic enter_stop(input bit deep, input bit off);
        deep_cfg_i = deep; osc_off_cfg_i = off; stop_req_i = 1'b1;
        @(negedge clk);
        check(core_down_req_o && cpu_clk_en_o && !bus_drain_req_o, "R5 core drain first",
              {core_down_req_o, cpu_clk_en_o, bus_drain_req_o}, 3'b110);
        check(mode_o == (deep ? 3 : 2), "R7 mode during entry", mode_o, deep ? 3 : 2);
        core_down_ack_i = 1'b1;
        @(negedge clk);
        check(!core_down_req_o && !cpu_clk_en_o && bus_drain_req_o && sys_clk_en_o,
              "R5 cpu off then bus drain",
              {core_down_req_o, cpu_clk_en_o, bus_drain_req_o, sys_clk_en_o}, 4'b0011);
        check(core_pwr_on_o, "R7 power kept during drain", core_pwr_on_o, 1);
        core_down_ack_i = 1'b0; bus_drain_ack_i = 1'b1;
        @(negedge clk);
        bus_drain_ack_i = 1'b0;
        if (deep) core_pwr_good_i = 1'b0;
        check(!sys_clk_en_o && !cpu_clk_en_o && !pll_en_o && !bus_drain_req_o, "R6 clocks stopped",
              {sys_clk_en_o, cpu_clk_en_o, pll_en_o, bus_drain_req_o}, 0);
        check(osc_en_o == !off, "R6 oscillator per config", osc_en_o, !off);
        check(core_pwr_on_o == !deep, "R7 power gate", core_pwr_on_o, !deep);
        check(mode_o == (deep ? 3 : 2), "R6 R7 stopped mode", mode_o, deep ? 3 : 2);
    endtask

    task automatic wake_measure(input logic [4:0] src, input int exp_n,
                                input logic [4:0] exp_cls, input bit deep);
        int n;
        bit mode_ok;
        int h;
        mode_ok = 1;
        wake_src_i = src;
        @(negedge clk);
        n = 1;
        wake_src_i = '0;
        check(wake_pulse_o, "R12 wake pulse", wake_pulse_o, 1);
        check(wake_class_o == exp_cls, "R12 wake class", wake_class_o, exp_cls);
        while (!sys_clk_en_o && n < 1000) begin
            if (mode_o != 3'd4 || cpu_clk_en_o) mode_ok = 0;
            @(negedge clk);
            n++;
            if (n == 2) check(!wake_pulse_o, "R12 pulse one cycle", wake_pulse_o, 0);
        end
        check(n == exp_n, "R9 clock release cycle", n, exp_n);
        check(mode_ok, "R11 waking mode", mode_ok, 1);
        if (!deep) begin
            check(cpu_clk_en_o && mode_o == 0 && osc_en_o && pll_en_o, "R9 back to normal",
                  {cpu_clk_en_o, mode_o}, 4'b1000);
        end else begin
            check(core_rst_o && core_pwr_on_o && !cpu_clk_en_o, "R10 power up with reset",
                  {core_rst_o, core_pwr_on_o, cpu_clk_en_o}, 3'b110);
            repeat (2) @(negedge clk);
            check(core_rst_o && mode_o == 4, "R10 waits for power good", {core_rst_o, mode_o}, 4'b1100);
            core_pwr_good_i = 1'b1;
            h = 0;
            @(negedge clk);
            while (core_rst_o && h < 100) begin
                h++;
                @(negedge clk);
            end
            check(h == 8, "R10 core reset length", h, 8);
            check(cpu_clk_en_o && mode_o == 0, "R10 cpu clock after reset", {cpu_clk_en_o, mode_o}, 4'b1000);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R1-to-R12 run actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        stop_req_i = 1'b1;  // high across reset: must not trigger (R1)
        repeat (3) @(negedge clk);
        check(mode_o == 0 && cpu_clk_en_o && sys_clk_en_o && osc_en_o && pll_en_o && core_pwr_on_o,
              "R1 reset outputs", mode_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!core_down_req_o && !bus_drain_req_o && !core_rst_o && mode_o == 0,
              "R1 no entry after reset", {core_down_req_o, bus_drain_req_o, core_rst_o}, 0);
        stop_req_i = 1'b0;
        @(negedge clk);

        // table walk: wake latency over count, oscillator and deep variants
        for (int i = 0; i < NV; i++) begin
            osc_cnt_i = 16'(V_OSC[i]); pll_cnt_i = 16'(V_PLL[i]);
            enter_stop(V_DEEP[i], V_OFF[i]);
            stop_req_i = 1'b0;
            wake_measure(V_SRC[i],
                         V_OFF[i] ? V_OSC[i] + V_PLL[i] + 3 : V_PLL[i] + 2,
                         V_SRC[i] & STOP_SET, V_DEEP[i]);
            @(negedge clk);
        end

        // R2 R3: idle entry and exit filtering
        core_standby_i = 1'b1;
        @(negedge clk);
        check(!cpu_clk_en_o && mode_o == 1 && sys_clk_en_o && osc_en_o && pll_en_o,
              "R2 idle gates cpu only", {cpu_clk_en_o, mode_o}, 4'b0001);
        wake_src_i = 5'b10000;
        repeat (2) @(negedge clk);
        check(mode_o == 1 && !cpu_clk_en_o, "R3 external reset ignored in idle", mode_o, 1);
        wake_en_i = 5'b11110; wake_src_i = 5'b00001;
        repeat (2) @(negedge clk);
        check(mode_o == 1 && !wake_pulse_o, "R3 masked interrupt ignored", mode_o, 1);
        wake_en_i = 5'b11111; wake_src_i = 5'b00100;
        @(negedge clk);
        wake_src_i = '0;
        check(mode_o == 0 && cpu_clk_en_o, "R3 tick exits idle", mode_o, 0);
        check(wake_pulse_o && wake_class_o == 5'b00100, "R12 idle wake class", wake_class_o, 5'b00100);
        core_standby_i = 1'b0;
        @(negedge clk);
        core_standby_i = 1'b1;
        @(negedge clk);
        wake_src_i = 5'b01000;
        @(negedge clk);
        wake_src_i = '0;
        check(mode_o == 0 && wake_class_o == 5'b01000, "R3 battery fault exits idle", wake_class_o, 5'b01000);
        core_standby_i = 1'b0;
        @(negedge clk);

        // R8: stop ignores battery fault and masked sources
        osc_cnt_i = 16'd1; pll_cnt_i = 16'd1;
        enter_stop(1'b0, 1'b1);
        wake_src_i = 5'b01000;
        repeat (3) @(negedge clk);
        check(mode_o == 2 && !sys_clk_en_o, "R8 battery fault ignored in stop", mode_o, 2);
        wake_en_i = 5'b11101; wake_src_i = 5'b00010;
        repeat (3) @(negedge clk);
        check(mode_o == 2 && !wake_pulse_o, "R8 masked alarm ignored", mode_o, 2);
        wake_en_i = 5'b11111;
        wake_measure(5'b10000, 5, 5'b10000, 1'b0);

        // R4: bit still high after wake does not retrigger
        repeat (5) @(negedge clk);
        check(!core_down_req_o && mode_o == 0, "R4 held bit no retrigger", mode_o, 0);
        stop_req_i = 1'b0;
        @(negedge clk);
        check(mode_o == 0, "R4 clear leaves normal", mode_o, 0);
        enter_stop(1'b0, 1'b0);
        stop_req_i = 1'b0;
        wake_measure(5'b00001, 3, 5'b00001, 1'b0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule